// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block takes the level-sensitive, active-low PCI interrupt wires and any other sources on a 16-bit general-purpose input vector. It turns them into four system interrupt request outputs. Each request channel has one configuration byte in a shared 32-bit control word. The byte holds an enable bit and the index of the input pin the channel watches. A direction register marks which pins are driven outward. A pin marked that way cannot raise a request.

The block also answers routing questions during bus enumeration. Given a device slot number and the interrupt pin value read from that device's configuration space (1..4 for INTA#..INTD#), it rotates the pin by the slot and looks the result up in a four-entry table of system interrupt numbers. System numbers 4 to 7 belong to request channels 0 to 3. The lookup flags a hit and names the channel when the answer lands in that range. All state is reached through a simple word-wide register write/read port.

Top module: `pci_irq_router`

## Requirements
- R1: After reset the control word reads 0, the direction register reads 0, every table entry reads 0xFF and irq_req is all zero.
- R2: Address 0 is the control word. Channel c owns bits [8c+7:8c]. Bit 7 of the byte is the enable and bits 3:0 are the pin index. Bits 6:4 are stored and read back but do not affect routing. Address 1 is the direction register in bits 15:0, with 1 meaning output; bits 31:16 read 0. Address 2 is the table, with entry k in bits [8k+7:8k].
- R3: An enabled channel whose selected pin is an input and is low drives its irq_req bit high at the clock edge after that condition appears. The bit falls at the edge after the pin returns high.
- R4: A channel whose enable bit is 0 never asserts its request, whatever the pin levels.
- R5: A selected pin whose direction bit is 1 never causes a request.
- R6: Channels are independent. Several channels may select the same pin, and each then asserts together.
- R7: For lk_pin in 1..4, lk_irq equals table entry ((lk_pin-1) + (lk_slot mod 4)) mod 4, combinationally.
- R8: For lk_pin outside 1..4, lk_irq is 0.
- R9: lk_hit is 1 exactly when lk_irq is in 4..7, and lk_ch then equals lk_irq-4. Otherwise lk_hit is 0, and a table value of 0xFF never hits.
- R10: Address 3 reads 0, and writes to it change no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| pin_in | input | 16 | General-purpose pin levels |
| pin_dir | output | 16 | Direction register, 1 = output |
| irq_req | output | 4 | Registered interrupt requests, channel 0 in bit 0 |
| lk_slot | input | 5 | Device slot number for lookup |
| lk_pin | input | 8 | Configuration-space interrupt pin value |
| lk_irq | output | 8 | Assigned system interrupt number, 0 if none |
| lk_hit | output | 1 | Lookup result maps to a request channel |
| lk_ch | output | 2 | Request channel of the lookup result |

## Verification
Routing is swept over every channel and every pin index in four patterns. In the first only the selected pin is low, which shows that the right pin is picked. In the second every pin except the selected one is low, which shows that no other pin leaks through. The third pattern repeats the first with enable clear, and the fourth with the pin marked as output. Together these separate the enable and direction gating from the selection. The lookup is swept over all slot numbers and all 256 pin values under two tables. One table holds out-of-range and 0xFF entries and the other holds all of 4..7, so the rotation, the invalid-pin zero and the hit decoding are each told apart.

// File: rtl/pir_pkg.sv
package pir_pkg;
   localparam int FIELD_W = 8;
   localparam int REG_W   = 32;
   localparam int EN_BIT  = 7;
   localparam logic [FIELD_W-1:0] NO_IRQ = 8'hFF;

   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_DIR  = 2'd1,
      A_TBL  = 2'd2,
      A_RSV  = 2'd3
   } pir_addr_e;
endpackage

// File: rtl/pir_regs.sv
module pir_regs
   import pir_pkg::*;
#(
   parameter int NUM_PINS = 16,
   parameter int NUM_CH   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_addr,
   input  logic [REG_W-1:0]    wr_data,
   input  logic [1:0]          rd_addr,
   output logic [REG_W-1:0]    rd_data,
   output logic [REG_W-1:0]    ctrl_o,
   output logic [NUM_PINS-1:0] dir_o,
   output logic [REG_W-1:0]    tbl_o
);
   logic [REG_W-1:0]    ctrl_q, tbl_q;
   logic [NUM_PINS-1:0] dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         dir_q  <= '0;
         tbl_q  <= {(REG_W/FIELD_W){NO_IRQ}};
      end else if (wr_en) begin
         case (pir_addr_e'(wr_addr))
            A_CTRL:  ctrl_q <= wr_data;
            A_DIR:   dir_q  <= wr_data[NUM_PINS-1:0];
            A_TBL:   tbl_q  <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (pir_addr_e'(rd_addr))
         A_CTRL:  rd_data = ctrl_q;
         A_DIR:   rd_data = REG_W'(dir_q);
         A_TBL:   rd_data = tbl_q;
         default: rd_data = '0;
      endcase
   end

   assign ctrl_o = ctrl_q;
   assign dir_o  = dir_q;
   assign tbl_o  = tbl_q;

   // R10: a write to the reserved word leaves the control word alone
   a_r10_rsv_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd3) |=> $stable(ctrl_q));
endmodule

// File: rtl/pir_channel.sv
module pir_channel #(
   parameter int NUM_PINS = 16,
   localparam int IDX_W   = $clog2(NUM_PINS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic [IDX_W-1:0]    sel_i,
   input  logic [NUM_PINS-1:0] pin_vec,
   input  logic [NUM_PINS-1:0] dir_vec,
   output logic                req_o
);
   logic pin_lvl, pin_out, req_q;

   assign pin_lvl = pin_vec[sel_i];
   assign pin_out = dir_vec[sel_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= en_i & ~pin_out & ~pin_lvl;
   end

   assign req_o = req_q;

   // R4: a request only follows an enabled cycle
   a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> $past(en_i));
   // R3: a request only follows a low level on the selected pin
   a_r3_level_low: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> $past(!pin_lvl));
   // R5: a pin driven outward never raises a request
   a_r5_output_pin: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> $past(!pin_out));
   // R3: a selected input held low while enabled raises the request
   a_r3_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !pin_out && !pin_lvl) |=> req_q);
endmodule

// File: rtl/pir_swizzle.sv
module pir_swizzle
   import pir_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int IRQ_BASE = 4,
   parameter int SLOT_W   = 5,
   localparam int CH_W    = $clog2(NUM_CH)
) (
   input  logic [REG_W-1:0]   tbl_i,
   input  logic [SLOT_W-1:0]  slot_i,
   input  logic [FIELD_W-1:0] pin_i,
   output logic [FIELD_W-1:0] irq_o,
   output logic               hit_o,
   output logic [CH_W-1:0]    ch_o
);
   logic               pin_ok;
   logic [CH_W-1:0]    idx;
   logic [FIELD_W-1:0] rel;
   logic               unused_slot_hi;

   assign unused_slot_hi = ^slot_i[SLOT_W-1:CH_W];
   assign pin_ok = (pin_i >= FIELD_W'(1)) && (pin_i <= FIELD_W'(NUM_CH));
   assign idx    = pin_i[CH_W-1:0] - CH_W'(1) + slot_i[CH_W-1:0];
   assign irq_o  = pin_ok ? tbl_i[idx*FIELD_W +: FIELD_W] : '0;
   assign rel    = irq_o - FIELD_W'(IRQ_BASE);
   assign hit_o  = (irq_o >= FIELD_W'(IRQ_BASE)) && (rel < FIELD_W'(NUM_CH));
   assign ch_o   = rel[CH_W-1:0];
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
   import pir_pkg::*;
#(
   parameter int NUM_PINS = 16,
   parameter int NUM_CH   = 4,
   parameter int IRQ_BASE = 4,
   parameter int SLOT_W   = 5,
   localparam int IDX_W   = $clog2(NUM_PINS),
   localparam int CH_W    = $clog2(NUM_CH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_addr,
   input  logic [31:0]         wr_data,
   input  logic [1:0]          rd_addr,
   output logic [31:0]         rd_data,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_dir,
   output logic [NUM_CH-1:0]   irq_req,
   input  logic [SLOT_W-1:0]   lk_slot,
   input  logic [7:0]          lk_pin,
   output logic [7:0]          lk_irq,
   output logic                lk_hit,
   output logic [CH_W-1:0]     lk_ch
);
   generate
      if (NUM_CH * FIELD_W != REG_W)
         $error("channel fields must fill the control word exactly");
      if (NUM_PINS < 2 || NUM_PINS > (1 << (FIELD_W-1)) || NUM_PINS > REG_W)
         $error("pin count does not fit the index field");
      if ((1 << IDX_W) != NUM_PINS)
         $error("pin count must be a power of two");
      if (SLOT_W < CH_W || IRQ_BASE + NUM_CH > 255)
         $error("slot width or interrupt base out of range");
   endgenerate

   logic [REG_W-1:0]    ctrl_w, tbl_w;
   logic [NUM_PINS-1:0] dir_w;

   pir_regs #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ctrl_o(ctrl_w), .dir_o(dir_w), .tbl_o(tbl_w)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pir_channel #(.NUM_PINS(NUM_PINS)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .en_i(ctrl_w[c*FIELD_W + EN_BIT]),
         .sel_i(ctrl_w[c*FIELD_W +: IDX_W]),
         .pin_vec(pin_in), .dir_vec(dir_w),
         .req_o(irq_req[c])
      );
   end

   pir_swizzle #(.NUM_CH(NUM_CH), .IRQ_BASE(IRQ_BASE), .SLOT_W(SLOT_W)) u_swz (
      .tbl_i(tbl_w), .slot_i(lk_slot), .pin_i(lk_pin),
      .irq_o(lk_irq), .hit_o(lk_hit), .ch_o(lk_ch)
   );

   assign pin_dir = dir_w;

   // R8: invalid pin values give no assignment
   a_r8_bad_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_pin == 8'd0 || lk_pin > 8'd4) |-> (lk_irq == 8'd0 && !lk_hit));
   // R9: a hit always carries a channel-range interrupt number
   a_r9_hit_range: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_irq == 8'(IRQ_BASE) + 8'(lk_ch)));
   // R1: requests start cleared
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> irq_req == '0);
endmodule

// File: tb/pci_irq_router_tb.sv
module pci_irq_router_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [15:0] pin_in = 16'hFFFF;
   logic [15:0] pin_dir;
   logic [3:0]  irq_req;
   logic [4:0]  lk_slot = '0;
   logic [7:0]  lk_pin = '0;
   logic [7:0]  lk_irq;
   logic        lk_hit;
   logic [1:0]  lk_ch;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pci_irq_router u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pin_in(pin_in), .pin_dir(pin_dir), .irq_req(irq_req),
      .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_irq(lk_irq),
      .lk_hit(lk_hit), .lk_ch(lk_ch)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      check(req, rd_data, exp);
   endtask

   function automatic logic [7:0] exp_irq(input logic [31:0] tbl, input int slot, input int pin);
      if (pin < 1 || pin > 4) return 8'd0;
      return tbl[(((pin - 1) + (slot % 4)) % 4) * 8 +: 8];
   endfunction

   task automatic sweep_lookup(input logic [31:0] tbl);
      wr(2'd2, tbl);
      for (int s = 0; s < 32; s++) begin
         for (int p = 0; p < 256; p++) begin
            logic [7:0] e;
            logic       eh;
            lk_slot = 5'(s); lk_pin = 8'(p);
            #1;
            e  = exp_irq(tbl, s, p);
            eh = (e >= 8'd4 && e <= 8'd7);
            if (p >= 1 && p <= 4) check("R7", {24'd0, lk_irq}, {24'd0, e});
            else                  check("R8", {24'd0, lk_irq}, 32'd0);
            check("R9 hit", {31'd0, lk_hit}, {31'd0, eh});
            if (eh) check("R9 ch", {30'd0, lk_ch}, 32'(e - 8'd4));
         end
      end
   endtask

   initial begin
      #100000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      rd_check("R1 ctrl", 2'd0, 32'h0);
      rd_check("R1 dir", 2'd1, 32'h0);
      rd_check("R1 tbl", 2'd2, 32'hFFFF_FFFF);
      check("R1 irq", {28'd0, irq_req}, 32'd0);

      // R2 readback of fields, including ignored bits 6:4
      wr(2'd0, 32'hF5A3_7C81);
      rd_check("R2 ctrl", 2'd0, 32'hF5A3_7C81);
      wr(2'd1, 32'hABCD_1234);
      rd_check("R2 dir", 2'd1, 32'h0000_1234);
      check("R2 pin_dir", {16'd0, pin_dir}, 32'h1234);
      wr(2'd2, 32'h0706_0504);
      rd_check("R2 tbl", 2'd2, 32'h0706_0504);

      // R10 reserved word
      wr(2'd3, 32'hFFFF_FFFF);
      rd_check("R10 rsv", 2'd3, 32'h0);
      rd_check("R10 ctrl", 2'd0, 32'hF5A3_7C81);
      rd_check("R10 dir", 2'd1, 32'h0000_1234);
      rd_check("R10 tbl", 2'd2, 32'h0706_0504);
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h0);
      tick();

      // Routing sweep over every channel and pin
      for (int c = 0; c < 4; c++) begin
         for (int p = 0; p < 16; p++) begin
            logic [15:0] only_low;
            only_low = ~(16'd1 << p);
            // R3: selected pin low, others high; bits 6:4 set must not matter (R2)
            wr(2'd0, 32'(8'h80 | 8'h70 * (p % 2) | 8'(p)) << (8 * c));
            pin_in = only_low;
            tick();
            check("R3 assert", {28'd0, irq_req}, 32'(4'd1 << c));
            pin_in = 16'hFFFF;
            tick();
            check("R3 release", {28'd0, irq_req}, 32'd0);
            // R3: every other pin low, selected high
            pin_in = ~only_low;
            tick();
            check("R3 other pins", {28'd0, irq_req}, 32'd0);
            // R5: selected pin low but marked as output
            wr(2'd1, 32'(~only_low));
            pin_in = only_low;
            tick();
            check("R5 output pin", {28'd0, irq_req}, 32'd0);
            wr(2'd1, 32'h0);
            // R4: enable clear, all pins low
            wr(2'd0, 32'(p) << (8 * c));
            pin_in = 16'h0000;
            tick();
            check("R4 disabled", {28'd0, irq_req}, 32'd0);
            pin_in = 16'hFFFF;
            wr(2'd0, 32'h0);
         end
      end

      // R6: all four channels watch pin 5
      wr(2'd0, 32'h8585_8585);
      pin_in = ~16'h0020;
      tick();
      check("R6 shared", {28'd0, irq_req}, 32'hF);
      // R6: two pins, two channels
      wr(2'd0, 32'h0089_0002 | 32'h0000_0080);
      pin_in = ~16'h0200;
      tick();
      check("R6 independent", {28'd0, irq_req}, 32'h4);
      pin_in = 16'hFFFF;
      wr(2'd0, 32'h0);
      tick();

      // R7/R8/R9 lookup sweeps
      sweep_lookup(32'hFF00_0904);
      sweep_lookup(32'h0604_0705);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule